// File: doc/BRIEF.md
# Dual-Format Serial Audio Port

This block is the codec side of a four-wire serial audio link. An external controller supplies the bit clock and the frame sync. The port follows them as a slave. Each frame carries 16-bit two's complement samples in both directions, most significant bit first. One bit moves in each direction per bit-clock period. Bits arriving on the serial input are collected into a parallel DAC word, which is announced by a one-cycle valid pulse. A parallel ADC word is taken at the start of each frame and sent out on the serial output.

Two framing formats are supported. In the long format the sync is held high over the data word, and the first data bit shares its bit period with the first high period of the sync. In the short format the sync is a pulse one bit period wide, and the first data bit comes in the following period. A frame holds two 16-bit slots back to back. A configuration input chooses the slot this port uses in both directions. The serial pins are oversampled by a faster core clock, which also runs the parallel side.

Top module: `sap_port`

## Requirements
- R1: While reset is asserted and after it is released, `sdo` is 0, `dac_valid` is 0 and `dac_sample` is 0 until the first complete slot has been received.
- R2: `sdo` changes only after a detected rising edge of `bclk`. In the selected slot it carries the ADC word, bit 15 first and bit 0 last, one bit per `bclk` period.
- R3: `sdi` is taken on falling edges of `bclk`. The 16 bits of the selected slot, first received bit as bit 15, appear on `dac_sample`.
- R4: With `long_mode`=1, bit 15 of slot 1 falls in the `bclk` period in which `fsync` is first seen high.
- R5: With `long_mode`=0, `fsync` is high for one `bclk` period, and bit 15 of slot 1 falls in the following period.
- R6: `slot_sel`=0 uses the first 16 data periods of the frame, and `slot_sel`=1 uses the next 16 periods, with no gap between the slots. `slot_sel` and `adc_sample` are taken at the frame start.
- R7: `sdo` is 0 in every `bclk` period outside the selected slot.
- R8: `dac_valid` is a single core-clock pulse, raised once per frame after bit 0 of the selected slot has been captured. Data in the other slot does not reach `dac_sample`.
- R9: `dac_sample` holds its value between `dac_valid` pulses.
- R10: A new rising edge of `fsync` restarts the frame. A slot that was cut short produces no `dac_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than `bclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| long_mode | input | 1 | 1 = long frame sync format, 0 = short frame sync format |
| slot_sel | input | 1 | 0 = first slot, 1 = second slot |
| bclk | input | 1 | Serial bit clock from the controller |
| fsync | input | 1 | Frame sync from the controller |
| sdi | input | 1 | Serial data into the port (DAC direction) |
| sdo | output | 1 | Serial data out of the port (ADC direction) |
| adc_sample | input | 16 | Parallel ADC word to transmit |
| dac_sample | output | 16 | Last complete received DAC word |
| dac_valid | output | 1 | One-cycle pulse when `dac_sample` is updated |

## Verification
The assertions assume that `fsync` and `sdi` change together with the `bclk` rising edge, so that after synchronisation they line up with the detected edge. They also assume that each `bclk` phase lasts several core clocks. The bench drives all three serial inputs in the same step, at a core-clock falling edge, and holds each `bclk` phase for six core clocks. It changes `long_mode` only during idle bit periods between frames. After any cut-short frame it leaves at least two idle periods with `fsync` low, so that the next frame begins with a real rising edge of `fsync`.

// File: rtl/sap_pkg.sv
// Shared defaults and types for the serial audio port.
// Assumes sample width is a power of two so bit/slot fields split cleanly.
package sap_pkg;
    localparam int DEF_SAMPLE_W    = 16;
    localparam int DEF_SLOTS       = 2;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/sap_edge_sync.sv
// Synchronises bclk, fsync and sdi into the core clock domain with equal
// depth and produces single-cycle rise/fall events of bclk.
// Assumes fsync and sdi change together with bclk rising edges.
module sap_edge_sync #(
    parameter int SYNC_STAGES = sap_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdi,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fsync_s,
    output logic sdi_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] sync_q [SYNC_STAGES];
    logic       bclk_last_q;

    // Purpose: shift the three pins through an equal-depth synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b000;
            bclk_last_q <= 1'b0;
        end else begin
            sync_q[0] <= {bclk, fsync, sdi};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            bclk_last_q <= sync_q[LAST][2];
        end
    end

    // Purpose: derive edge events and aligned data from the last stage.
    always_comb begin
        bclk_rise = sync_q[LAST][2] & ~bclk_last_q;
        bclk_fall = ~sync_q[LAST][2] & bclk_last_q;
        fsync_s   = sync_q[LAST][1];
        sdi_s     = sync_q[LAST][0];
    end
endmodule

// File: rtl/sap_frame_timer.sv
// Tracks the bit position inside a frame, counted at each bclk rise.
// Long format starts the frame in the period fsync rises; short format
// starts it one period later. Position saturates at an idle value.
module sap_frame_timer #(
    parameter int SAMPLE_W = sap_pkg::DEF_SAMPLE_W,
    parameter int SLOTS    = sap_pkg::DEF_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bclk_rise,
    input  logic                        fsync_s,
    input  logic                        long_mode,
    input  logic [$clog2(SLOTS)-1:0]    slot_sel,
    output logic                        in_slot,
    output logic [$clog2(SAMPLE_W)-1:0] bit_idx,
    output logic                        frame_start
);
    localparam int BIT_W    = $clog2(SAMPLE_W);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int IDLE_POS = SAMPLE_W * SLOTS;
    localparam int POS_W    = $clog2(IDLE_POS) + 1;
    localparam int FIELD_W  = POS_W - BIT_W;

    sap_pkg::frame_fmt_e fmt;
    logic [POS_W-1:0]    pos_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                fs_at_rise_q;
    logic                fs_rose_q;
    logic                fs_edge;
    logic                start;

    // Purpose: decide whether this bclk rise opens a new frame.
    always_comb begin
        fmt     = sap_pkg::frame_fmt_e'(long_mode);
        fs_edge = fsync_s & ~fs_at_rise_q;
        start   = (fmt == sap_pkg::FMT_LONG) ? fs_edge : fs_rose_q;
    end

    // Purpose: advance or restart the frame position on each bclk rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q        <= POS_W'(IDLE_POS);
            slot_q       <= '0;
            fs_at_rise_q <= 1'b0;
            fs_rose_q    <= 1'b0;
            frame_start  <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (bclk_rise) begin
                fs_at_rise_q <= fsync_s;
                fs_rose_q    <= fs_edge;
                if (start) begin
                    pos_q       <= '0;
                    slot_q      <= slot_sel;
                    frame_start <= 1'b1;
                end else if (pos_q != POS_W'(IDLE_POS)) begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // Purpose: split the position into slot field and bit index.
    always_comb begin
        in_slot = (pos_q[POS_W-1:BIT_W] == FIELD_W'(slot_q));
        bit_idx = pos_q[BIT_W-1:0];
    end

    a_r6_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_W'(IDLE_POS));
    a_r10_restart_long: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && long_mode && fsync_s && !fs_at_rise_q) |=> (pos_q == '0));
endmodule

// File: rtl/sap_tx.sv
// Serialises the ADC word onto sdo, one bit per bclk period, MSB first.
// The word is captured at frame start; sdo is low outside the slot.
// Assumes timer outputs settle the cycle after a bclk rise.
module sap_tx #(
    parameter int SAMPLE_W = sap_pkg::DEF_SAMPLE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bclk_rise,
    input  logic                        frame_start,
    input  logic                        in_slot,
    input  logic [$clog2(SAMPLE_W)-1:0] bit_idx,
    input  logic [SAMPLE_W-1:0]         adc_sample,
    output logic                        sdo
);
    localparam int BIT_W = $clog2(SAMPLE_W);

    logic                rise_d_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] src;
    logic [BIT_W-1:0]    sel;

    // Purpose: pick the word source and the bit of the current period.
    always_comb begin
        src = frame_start ? adc_sample : word_q;
        sel = BIT_W'(SAMPLE_W - 1) - bit_idx;
    end

    // Purpose: latch the word at frame start and launch one bit per rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_d_q <= 1'b0;
            word_q   <= '0;
            sdo      <= 1'b0;
        end else begin
            rise_d_q <= bclk_rise;
            if (rise_d_q) begin
                if (frame_start) word_q <= adc_sample;
                sdo <= in_slot ? src[sel] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/sap_rx.sv
// Collects sdi bits taken on bclk falls within the selected slot and
// publishes the word with a one-cycle valid after its last bit.
module sap_rx #(
    parameter int SAMPLE_W = sap_pkg::DEF_SAMPLE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bclk_fall,
    input  logic                        sdi_s,
    input  logic                        in_slot,
    input  logic [$clog2(SAMPLE_W)-1:0] bit_idx,
    output logic [SAMPLE_W-1:0]         dac_sample,
    output logic                        dac_valid
);
    localparam int BIT_W = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] shift_q;
    logic [SAMPLE_W-1:0] shift_nxt;

    // Purpose: form the shift register value including the new bit.
    always_comb shift_nxt = {shift_q[SAMPLE_W-2:0], sdi_s};

    // Purpose: shift in slot bits and publish on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q    <= '0;
            dac_sample <= '0;
            dac_valid  <= 1'b0;
        end else begin
            dac_valid <= 1'b0;
            if (bclk_fall && in_slot) begin
                shift_q <= shift_nxt;
                if (bit_idx == BIT_W'(SAMPLE_W - 1)) begin
                    dac_sample <= shift_nxt;
                    dac_valid  <= 1'b1;
                end
            end
        end
    end

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> $stable(dac_sample));
    a_r3_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(bclk_fall));
endmodule

// File: rtl/sap_port.sv
// Codec-side serial audio port: slave to bclk/fsync, short or long frame
// sync, two slots per frame. Assumes bclk phases span several clk cycles.
module sap_port #(
    parameter int SAMPLE_W    = sap_pkg::DEF_SAMPLE_W,
    parameter int SLOTS       = sap_pkg::DEF_SLOTS,
    parameter int SYNC_STAGES = sap_pkg::DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                long_mode,
    input  logic                slot_sel,
    input  logic                bclk,
    input  logic                fsync,
    input  logic                sdi,
    output logic                sdo,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [SAMPLE_W-1:0] dac_sample,
    output logic                dac_valid
);
    localparam int BIT_W  = $clog2(SAMPLE_W);
    localparam int SLOT_W = $clog2(SLOTS);

    logic             bclk_rise;
    logic             bclk_fall;
    logic             fsync_s;
    logic             sdi_s;
    logic             in_slot;
    logic             frame_start;
    logic [BIT_W-1:0] bit_idx;

    sap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdi(sdi),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fsync_s(fsync_s), .sdi_s(sdi_s)
    );

    sap_frame_timer #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .fsync_s(fsync_s),
        .long_mode(long_mode), .slot_sel(SLOT_W'(slot_sel)),
        .in_slot(in_slot), .bit_idx(bit_idx), .frame_start(frame_start)
    );

    sap_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise),
        .frame_start(frame_start), .in_slot(in_slot), .bit_idx(bit_idx),
        .adc_sample(adc_sample), .sdo(sdo)
    );

    sap_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .sdi_s(sdi_s),
        .in_slot(in_slot), .bit_idx(bit_idx),
        .dac_sample(dac_sample), .dac_valid(dac_valid)
    );

    a_r2_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(bclk_rise, 2));
    a_r8_valid_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> ($past(in_slot) && $past(bit_idx) == BIT_W'(SAMPLE_W - 1)));
endmodule

// File: tb/sap_port_bench.sv
module sap_port_bench;
    localparam int CLK_NS = 10;
    localparam int HALF   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode = 1'b0;
    logic        slot_sel = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [15:0] adc_sample = '0;
    logic [15:0] dac_sample;
    logic        dac_valid;

    logic [15:0] exp_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sap_port u_sap_port (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .slot_sel(slot_sel),
        .bclk(bclk), .fsync(fsync), .sdi(sdi), .sdo(sdo),
        .adc_sample(adc_sample), .dac_sample(dac_sample), .dac_valid(dac_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: each valid pulse pops one expected DAC word (R3, R8, R6).
    always @(negedge clk) begin
        if (rst_n && dac_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8/R10 unexpected dac_valid", dac_sample, 16'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(dac_sample == e, "R3/R8 dac_sample", dac_sample, e);
            end
        end
    end

    task automatic idle(input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            bclk = 1'b1; fsync = 1'b0; sdi = 1'b0;
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    // Driver: plays one frame and pushes the expected DAC word.
    task automatic run_frame(input bit lfs, input bit slot,
                             input logic [15:0] adc, input logic [15:0] w1,
                             input logic [15:0] w2, input int nper,
                             input bit full, input string req);
        logic [15:0] got = '0;
        int          quiet_bad = 0;
        int          base = lfs ? 0 : 1;
        int          lo = slot ? 16 : 0;
        long_mode  = lfs;
        slot_sel   = slot;
        adc_sample = adc;
        if (full) exp_q.push_back(slot ? w2 : w1);
        for (int p = 0; p < nper; p++) begin
            int idx = p - base;
            logic d = 1'b0;
            if (idx >= 0 && idx < 16) d = w1[15 - idx];
            else if (idx >= 16 && idx < 32) d = w2[31 - idx];
            @(negedge clk);
            bclk = 1'b1;
            fsync = lfs ? (p < 16) : (p == 0);
            sdi = d;
            repeat (HALF - 1) @(negedge clk);
            if (idx >= lo && idx < lo + 16) got[15 - (idx - lo)] = sdo;
            else if (sdo !== 1'b0) quiet_bad++;
            @(negedge clk);
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
        if (full) begin
            check(got == adc, {req, " R2/R6 sdo word"}, got, adc);
            check(quiet_bad == 0, "R7 sdo low outside slot",
                  16'(quiet_bad), 16'h0);
        end
        idle(2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sdo === 1'b0 && dac_valid === 1'b0 && dac_sample === 16'h0,
              "R1 reset state", dac_sample, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo === 1'b0 && dac_valid === 1'b0 && dac_sample === 16'h0,
              "R1 after reset", dac_sample, 16'h0);
        idle(2);
        run_frame(1, 0, 16'hA5C3, 16'h1234, 16'hFFFF, 36, 1, "R4 long slot1");
        run_frame(1, 1, 16'h8001, 16'hAAAA, 16'h5555, 36, 1, "R4 long slot2");
        run_frame(0, 0, 16'h7FFF, 16'h8000, 16'h0F0F, 36, 1, "R5 short slot1");
        run_frame(0, 1, 16'h0001, 16'hFFFF, 16'hC3A5, 36, 1, "R5 short slot2");
        check(dac_sample == 16'hC3A5, "R9 dac_sample held", dac_sample, 16'hC3A5);
        // R10: long frame cut after 8 bits, then a full frame
        run_frame(1, 0, 16'h1111, 16'hDEAD, 16'h0000, 8, 0, "R10 cut");
        check(exp_q.size() == 0, "R10 no valid for cut slot",
              16'(exp_q.size()), 16'h0);
        run_frame(1, 0, 16'h3C3C, 16'h6E21, 16'h9999, 36, 1, "R10 long restart");
        run_frame(0, 1, 16'h2222, 16'hBEEF, 16'hF00D, 12, 0, "R10 cut short");
        run_frame(0, 1, 16'hFEDC, 16'h0000, 16'h4B1D, 36, 1, "R10 short restart");
        run_frame(0, 0, 16'h00FF, 16'h8421, 16'h1248, 36, 1, "R6 switch short");
        run_frame(1, 1, 16'hFF00, 16'h7777, 16'h0180, 36, 1, "R6 switch long");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8 one valid per frame",
              16'(exp_q.size()), 16'h0);
        check(dac_sample == 16'h0180, "R9 final dac_sample", dac_sample, 16'h0180);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule